// File: doc/BRIEF.md
# Idle State Selector with Wake-Delay Estimator

This block picks a low-power state for one core. It holds a small table of idle-state descriptors, written one slot at a time. Each descriptor gives an entry latency, an exit latency, a break-even residency, an optional explicit wakeup latency, a flag saying that the core's local timer is lost in that state, and a valid bit. Software supplies two things: the predicted time until the next wake, and the largest wake latency it can tolerate. On a select strobe the block returns the deepest state that passes both tests. If no table state passes, it returns the implicit wait-for-interrupt standby state, which is never stored in the table.

Table slots are ordered from shallow to deep by index. A state qualifies when it is valid, when the predicted residency is at least its break-even residency, and when its effective wakeup latency is within the ceiling. The effective wakeup latency is the programmed value. When no value is programmed, it is the entry latency plus the exit latency.

An enter strobe commits the core to the most recently selected state. It captures a timestamp from a free-running microsecond counter, and it snapshots that state's latencies. On a query strobe the block reports the worst-case wake delay at that moment. The delay is the exit latency, plus whatever part of the non-abortable entry window has not yet elapsed.

Top module: `idle_selector`

## Requirements
- R1: After reset, sel_done, sel_deep, sel_idx, sel_timer_lost, delay_valid and delay_us are all zero, and every table slot is invalid.
- R2: A table state qualifies only if pred_us is greater than or equal to its minimum residency; equality qualifies.
- R3: A table state whose effective wakeup latency is greater than lat_limit is never chosen; equality is allowed.
- R4: When a slot is written with wr_has_wake = 0, its effective wakeup latency is wr_entry + wr_exit, and its wr_wake field has no effect.
- R5: Among the qualifying slots, the one with the highest index is chosen.
- R6: A slot written with wr_valid = 0 is never chosen. Rewriting it with wr_valid = 1 makes it selectable.
- R7: When no slot qualifies, the result is standby: sel_deep = 0, sel_idx = 0, sel_timer_lost = 0.
- R8: sel_timer_lost equals the timer-lost flag of the chosen slot.
- R9: The selection outputs update on the clock edge that samples sel_req, with sel_done high for exactly the following cycle. At all other times they hold their values.
- R10: A delay_req sampled at an edge gives delay_valid high in the next cycle, with delay_us = exit + max(entry − (now − t_enter), 0). Here now and t_enter are microsecond counter values, and entry and exit are the latencies of the entered state.
- R11: Before any enter, and after entering standby, the reported delay is 0.
- R12: The microsecond counter is zero after reset and advances once every CYC_PER_US clock cycles. enter_req stores its current value and snapshots the state held in the selection outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | IDX_W | Slot to write |
| wr_valid | input | 1 | Slot holds a usable state |
| wr_timer_lost | input | 1 | Local timer lost in this state |
| wr_has_wake | input | 1 | wr_wake is programmed |
| wr_entry | input | 16 | Entry latency, us |
| wr_exit | input | 16 | Exit latency, us |
| wr_min_res | input | 16 | Break-even residency, us |
| wr_wake | input | 16 | Explicit wakeup latency, us |
| sel_req | input | 1 | Select strobe |
| pred_us | input | TIME_W | Predicted time to next wake, us |
| lat_limit | input | 16 | Largest tolerable wakeup latency, us |
| sel_done | output | 1 | Selection result updated |
| sel_deep | output | 1 | 1: table state chosen, 0: standby |
| sel_idx | output | IDX_W | Chosen slot (0 when standby) |
| sel_timer_lost | output | 1 | Chosen state loses the local timer |
| enter_req | input | 1 | Commit to the selected state |
| delay_req | input | 1 | Request current wake delay |
| delay_valid | output | 1 | delay_us updated |
| delay_us | output | 17 | Worst-case wake delay, us |

## Verification
The bench builds the block with NUM_STATES = 4, TIME_W = 32 and CYC_PER_US = 3. This makes the prescaler a non-trivial divider, so the microsecond time base can be predicted from a cycle count kept in the bench. A four-slot table is large enough to hold a hole (an invalid middle slot), a slot whose wakeup latency is left unprogrammed, and a deepest slot that only an exact residency or latency ceiling admits. The wake-delay checks are placed early in the entry window, partway through it, and after it has fully elapsed, so both branches of the saturating subtraction are reached.

// File: rtl/idle_sel_pkg.sv
package idle_sel_pkg;

    localparam int LAT_W = 16;

    typedef logic [LAT_W-1:0] lat_t;
    typedef logic [LAT_W:0]   wlat_t;

    typedef struct packed {
        logic valid;
        logic timer_lost;
        logic has_wake;
        lat_t entry_lat;
        lat_t exit_lat;
        lat_t min_res;
        lat_t wake_lat;
    } desc_t;

    // Wakeup latency used for the ceiling test.
    function automatic wlat_t eff_wake(desc_t d);
        if (d.has_wake)
            return {1'b0, d.wake_lat};
        return {1'b0, d.entry_lat} + {1'b0, d.exit_lat};
    endfunction

endpackage

// File: rtl/idle_desc_table.sv
module idle_desc_table
    import idle_sel_pkg::*;
#(
    parameter int NUM_STATES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  desc_t                   wr_desc,
    output desc_t [NUM_STATES-1:0]  tbl
);

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                tbl[g] <= wr_desc;
        end
    end

endmodule

// File: rtl/idle_eligibility.sv
module idle_eligibility
    import idle_sel_pkg::*;
#(
    parameter int NUM_STATES = 8,
    parameter int TIME_W     = 32
) (
    input  desc_t [NUM_STATES-1:0] tbl,
    input  logic  [TIME_W-1:0]     pred_us,
    input  lat_t                   lat_limit,
    output logic  [NUM_STATES-1:0] elig
);

    localparam int PAD_W = TIME_W - LAT_W;

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_test
        logic res_ok;
        logic lat_ok;
        always_comb begin
            res_ok  = pred_us >= {{PAD_W{1'b0}}, tbl[g].min_res};
            lat_ok  = eff_wake(tbl[g]) <= {1'b0, lat_limit};
            elig[g] = tbl[g].valid && res_ok && lat_ok;
        end
    end

endmodule

// File: rtl/idle_pick.sv
module idle_pick #(
    parameter int NUM_STATES = 8,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_STATES-1:0] elig,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);

    // Ascending scan: a later (deeper) hit overrides an earlier one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_STATES; i++) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/idle_wake_est.sv
module idle_wake_est
    import idle_sel_pkg::*;
#(
    parameter int TIME_W     = 32,
    parameter int CYC_PER_US = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enter_req,
    input  lat_t  enter_entry,
    input  lat_t  enter_exit,
    input  logic  delay_req,
    output logic  delay_valid,
    output wlat_t delay_us
);

    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int PAD_W = TIME_W - LAT_W;

    logic [PRE_W-1:0]  pre_cnt;
    logic [TIME_W-1:0] now_us;
    logic [TIME_W-1:0] t_enter;
    lat_t              held_entry;
    lat_t              held_exit;
    logic [TIME_W-1:0] elapsed;
    lat_t              remain;
    wlat_t             delay_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            now_us  <= '0;
        end else if (pre_cnt == PRE_W'(CYC_PER_US - 1)) begin
            pre_cnt <= '0;
            now_us  <= now_us + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_enter    <= '0;
            held_entry <= '0;
            held_exit  <= '0;
        end else if (enter_req) begin
            t_enter    <= now_us;
            held_entry <= enter_entry;
            held_exit  <= enter_exit;
        end
    end

    always_comb begin
        elapsed = now_us - t_enter;
        if (elapsed >= {{PAD_W{1'b0}}, held_entry})
            remain = '0;
        else
            remain = held_entry - elapsed[LAT_W-1:0];
        delay_next = {1'b0, held_exit} + {1'b0, remain};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            delay_valid <= 1'b0;
            delay_us    <= '0;
        end else begin
            delay_valid <= delay_req;
            if (delay_req)
                delay_us <= delay_next;
        end
    end

endmodule

// File: rtl/idle_selector.sv
module idle_selector
    import idle_sel_pkg::*;
#(
    parameter int NUM_STATES = 8,
    parameter int TIME_W     = 32,
    parameter int CYC_PER_US = 100,
    localparam int IDX_W     = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_timer_lost,
    input  logic              wr_has_wake,
    input  logic [15:0]       wr_entry,
    input  logic [15:0]       wr_exit,
    input  logic [15:0]       wr_min_res,
    input  logic [15:0]       wr_wake,
    input  logic              sel_req,
    input  logic [TIME_W-1:0] pred_us,
    input  logic [15:0]       lat_limit,
    output logic              sel_done,
    output logic              sel_deep,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_timer_lost,
    input  logic              enter_req,
    input  logic              delay_req,
    output logic              delay_valid,
    output logic [16:0]       delay_us
);

    desc_t                  wr_desc;
    desc_t [NUM_STATES-1:0] tbl;
    logic  [NUM_STATES-1:0] elig_vec;
    logic                   pick_found;
    logic  [IDX_W-1:0]      pick_idx;
    lat_t                   enter_entry;
    lat_t                   enter_exit;

    always_comb begin
        wr_desc.valid      = wr_valid;
        wr_desc.timer_lost = wr_timer_lost;
        wr_desc.has_wake   = wr_has_wake;
        wr_desc.entry_lat  = wr_entry;
        wr_desc.exit_lat   = wr_exit;
        wr_desc.min_res    = wr_min_res;
        wr_desc.wake_lat   = wr_wake;
    end

    idle_desc_table #(.NUM_STATES(NUM_STATES), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_desc (wr_desc),
        .tbl     (tbl)
    );

    idle_eligibility #(.NUM_STATES(NUM_STATES), .TIME_W(TIME_W)) u_elig (
        .tbl       (tbl),
        .pred_us   (pred_us),
        .lat_limit (lat_limit),
        .elig      (elig_vec)
    );

    idle_pick #(.NUM_STATES(NUM_STATES), .IDX_W(IDX_W)) u_pick (
        .elig  (elig_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_done       <= 1'b0;
            sel_deep       <= 1'b0;
            sel_idx        <= '0;
            sel_timer_lost <= 1'b0;
        end else begin
            sel_done <= sel_req;
            if (sel_req) begin
                sel_deep       <= pick_found;
                sel_idx        <= pick_idx;
                sel_timer_lost <= pick_found && tbl[pick_idx].timer_lost;
            end
        end
    end

    // Standby has zero latencies, so its wake delay is always zero.
    always_comb begin
        enter_entry = sel_deep ? tbl[sel_idx].entry_lat : '0;
        enter_exit  = sel_deep ? tbl[sel_idx].exit_lat  : '0;
    end

    idle_wake_est #(.TIME_W(TIME_W), .CYC_PER_US(CYC_PER_US)) u_wake (
        .clk         (clk),
        .rst         (rst),
        .enter_req   (enter_req),
        .enter_entry (enter_entry),
        .enter_exit  (enter_exit),
        .delay_req   (delay_req),
        .delay_valid (delay_valid),
        .delay_us    (delay_us)
    );

endmodule

// File: rtl/idle_selector_chk.sv
module idle_selector_chk #(
    parameter int NUM_STATES = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sel_req,
    input logic                  sel_done,
    input logic                  sel_deep,
    input logic [IDX_W-1:0]      sel_idx,
    input logic                  sel_timer_lost,
    input logic                  delay_req,
    input logic                  delay_valid,
    input logic [NUM_STATES-1:0] elig
);

    logic [NUM_STATES-1:0] elig_q;

    always_ff @(posedge clk) begin
        if (rst) elig_q <= '0;
        else     elig_q <= elig;
    end

    p_done_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        sel_req |=> sel_done);

    p_done_only_after_req_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_req |=> !sel_done);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_req |=> $stable(sel_idx) && $stable(sel_deep) && $stable(sel_timer_lost));

    p_choice_eligible_r2: assert property (@(posedge clk) disable iff (rst)
        sel_done && sel_deep |-> elig_q[sel_idx]);

    p_choice_deepest_r5: assert property (@(posedge clk) disable iff (rst)
        sel_done && sel_deep |-> (elig_q >> sel_idx) == NUM_STATES'(1));

    p_none_gives_standby_r7: assert property (@(posedge clk) disable iff (rst)
        sel_done && elig_q == '0 |-> !sel_deep);

    p_standby_fields_r7: assert property (@(posedge clk) disable iff (rst)
        !sel_deep |-> sel_idx == '0 && !sel_timer_lost);

    p_delay_valid_r10: assert property (@(posedge clk) disable iff (rst)
        delay_req |=> delay_valid);

endmodule

bind idle_selector idle_selector_chk #(.NUM_STATES(NUM_STATES), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_req        (sel_req),
    .sel_done       (sel_done),
    .sel_deep       (sel_deep),
    .sel_idx        (sel_idx),
    .sel_timer_lost (sel_timer_lost),
    .delay_req      (delay_req),
    .delay_valid    (delay_valid),
    .elig           (elig_vec)
);

// File: tb/idle_selector_tb.sv
`timescale 1ns/1ps
module idle_selector_tb;

    localparam int N      = 4;
    localparam int TW     = 32;
    localparam int CYC    = 3;
    localparam int IW     = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0, wr_timer_lost = 1'b0, wr_has_wake = 1'b0;
    logic [15:0]   wr_entry = '0, wr_exit = '0, wr_min_res = '0, wr_wake = '0;
    logic          sel_req = 1'b0;
    logic [TW-1:0] pred_us = '0;
    logic [15:0]   lat_limit = '0;
    logic          sel_done, sel_deep, sel_timer_lost;
    logic [IW-1:0] sel_idx;
    logic          enter_req = 1'b0, delay_req = 1'b0;
    logic          delay_valid;
    logic [16:0]   delay_us;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ts_exp = 0;
    int ent_exp = 0;
    int ext_exp = 0;

    always #10 clk = ~clk;

    // Edges seen with reset low: the design's time base is cyc / CYC.
    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    idle_selector #(.NUM_STATES(N), .TIME_W(TW), .CYC_PER_US(CYC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_timer_lost(wr_timer_lost), .wr_has_wake(wr_has_wake), .wr_entry(wr_entry),
        .wr_exit(wr_exit), .wr_min_res(wr_min_res), .wr_wake(wr_wake),
        .sel_req(sel_req), .pred_us(pred_us), .lat_limit(lat_limit),
        .sel_done(sel_done), .sel_deep(sel_deep), .sel_idx(sel_idx),
        .sel_timer_lost(sel_timer_lost), .enter_req(enter_req), .delay_req(delay_req),
        .delay_valid(delay_valid), .delay_us(delay_us)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input bit v, input bit tl, input bit hw,
                              input int ent, input int ext, input int mr, input int wk);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v; wr_timer_lost = tl;
        wr_has_wake = hw; wr_entry = 16'(ent); wr_exit = 16'(ext);
        wr_min_res = 16'(mr); wr_wake = 16'(wk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_select(input string tag, input int pred, input int lim,
                             input bit deep, input int idx, input bit tl);
        @(negedge clk);
        sel_req = 1'b1; pred_us = TW'(pred); lat_limit = 16'(lim);
        @(negedge clk);
        sel_req = 1'b0;
        chk({tag, " done"}, int'(sel_done), 1);
        chk({tag, " deep"}, int'(sel_deep), int'(deep));
        chk({tag, " idx"},  int'(sel_idx), idx);
        chk({tag, " timer_lost"}, int'(sel_timer_lost), int'(tl));
    endtask

    task automatic do_enter(input int ent, input int ext);
        @(negedge clk);
        enter_req = 1'b1;
        ts_exp  = cyc / CYC;
        ent_exp = ent;
        ext_exp = ext;
        @(negedge clk);
        enter_req = 1'b0;
    endtask

    task automatic do_query(input string tag);
        int now_v, el, rem;
        @(negedge clk);
        delay_req = 1'b1;
        now_v = cyc / CYC;
        el  = now_v - ts_exp;
        rem = (el >= ent_exp) ? 0 : ent_exp - el;
        @(negedge clk);
        delay_req = 1'b0;
        chk({tag, " valid"}, int'(delay_valid), 1);
        chk({tag, " delay"}, int'(delay_us), ext_exp + rem);
    endtask

    task automatic test_reset();
        chk("R1 sel_done", int'(sel_done), 0);
        chk("R1 sel_deep", int'(sel_deep), 0);
        chk("R1 sel_idx", int'(sel_idx), 0);
        chk("R1 timer_lost", int'(sel_timer_lost), 0);
        chk("R1 delay_valid", int'(delay_valid), 0);
        chk("R1 delay_us", int'(delay_us), 0);
        // Empty table: every slot invalid after reset.
        do_select("R1 empty table", 100000, 16'hFFFF, 0, 0, 0);
        ent_exp = 0; ext_exp = 0;
        do_query("R11 before enter");
    endtask

    task automatic test_selection();
        do_select("R5 deepest", 10000, 16'hFFFF, 1, 3, 1);
        do_select("R2 below min res / R6 hole", 2699, 16'hFFFF, 1, 1, 1);
        do_select("R2 equal min res", 2700, 16'hFFFF, 1, 3, 1);
        do_select("R3 ceiling below", 10000, 1499, 1, 1, 1);
        do_select("R3 ceiling equal", 10000, 1500, 1, 3, 1);
        do_select("R8 shallow flag clear", 80, 16'hFFFF, 1, 0, 0);
        do_select("R7 no residency fits", 79, 16'hFFFF, 0, 0, 0);
        do_select("R4 sum exceeds ceiling", 10000, 59, 0, 0, 0);
        do_select("R4 sum meets ceiling", 10000, 60, 1, 0, 0);
    endtask

    task automatic test_hold();
        do_select("R9 setup", 10000, 16'hFFFF, 1, 3, 1);
        @(negedge clk);
        chk("R9 done pulse ends", int'(sel_done), 0);
        pred_us = 0; lat_limit = 0;
        @(negedge clk);
        chk("R9 idx held", int'(sel_idx), 3);
        chk("R9 deep held", int'(sel_deep), 1);
    endtask

    task automatic test_valid_rewrite();
        write_slot(2, 1, 1, 0, 250, 500, 950, 0);
        do_select("R6 slot now valid", 1000, 1499, 1, 2, 1);
    endtask

    task automatic test_delay();
        do_select("R10 select", 10000, 16'hFFFF, 1, 3, 1);
        do_enter(600, 1100);
        do_query("R10 early");
        repeat (300) @(negedge clk);
        do_query("R10 mid window");
        repeat (2000) @(negedge clk);
        do_query("R12 window elapsed");
        chk("R10 saturated value", int'(delay_us), 1100);
        do_select("R11 standby select", 10, 16'hFFFF, 0, 0, 0);
        do_enter(0, 0);
        repeat (5) @(negedge clk);
        do_query("R11 standby entered");
        chk("R11 standby delay zero", int'(delay_us), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        write_slot(0, 1, 0, 0, 20, 40, 80, 5);
        write_slot(1, 1, 1, 1, 50, 100, 250, 130);
        write_slot(2, 0, 1, 0, 250, 500, 950, 0);
        write_slot(3, 1, 1, 1, 600, 1100, 2700, 1500);
        test_selection();
        test_hold();
        test_valid_rewrite();
        test_delay();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule